// File: doc/BRIEF.md
# Per-Port Status LED Controller

This block turns the status of each network port into the drive for one indicator LED per port. Each port supplies four status bits: link good, polarity good, full duplex, and an error flag that management software writes into bit 7 of that port's register. The block is replicated across `NUM_PORTS` ports. A single mode decides how all of the LEDs are driven.

In normal mode the LED tells the operator which fault is present. A healthy port is dark. An error is shown as solid light, a lost link as a fast blink, and reversed polarity as a slow blink. In enhanced mode the LED is treated as a two-colour device. One colour shows a good full-duplex link, the other shows a good half-duplex link, and the LED is dark when the link has failed. The mode is taken from a strap pin while reset is held, and a low strap selects normal mode.

Each port runs a state machine with six states:
- `LED_DARK`
- `LED_SOLID`
- `LED_FAST_BLINK`
- `LED_SLOW_BLINK`
- `LED_COLOUR_A`
- `LED_COLOUR_B`

On every clock the state machine computes a target state from the mode and the port's status bits. There are two kinds of transition:
- **Condition change:** when the target differs from the current state, the machine moves to the target and restarts its blink phase in the lit half.
- **Blink toggle:** in a blink state with no condition change, the machine stays put and counts prescaler ticks, inverting the lit/dark level after each half period.

A shared prescaler produces one tick every `TICK_DIV` clocks. At 10 MHz the default of 10000 gives a 1 ms tick, so the default half periods of 200 and 800 ticks give periods of 400 ms and 1600 ms.

Top module: `port_led_ctrl`

## Requirements
- R1: While `rst_n` is low, every `led_on` and `led_colour_b` bit is 0.
- R2: In normal mode, a port with `err_flag`=0, `link_ok`=1 and `pol_ok`=1 has its LED dark (`led_on`=0) from the next clock edge.
- R3: In normal mode, `err_flag`=1 makes the port's LED lit solid (`led_on`=1) from the next clock edge, whatever its link and polarity.
- R4: In normal mode, a port with `err_flag`=0 and `link_ok`=0 blinks fast: lit for `FAST_HALF_TICKS` ticks, then dark for the same count, repeating.
- R5: In normal mode, a port with `err_flag`=0, `link_ok`=1 and `pol_ok`=0 blinks slowly: lit for `SLOW_HALF_TICKS` ticks, then dark for the same count.
- R6: When faults coincide, the error flag outranks a lost link, and a lost link outranks bad polarity.
- R7: When a port's displayed condition changes, its blink restarts in the lit half with a full half period.
- R8: In enhanced mode, `link_ok`=1 with `full_dup`=1 gives `led_on`=1 and `led_colour_b`=0 (colour A) from the next edge.
- R9: In enhanced mode, `link_ok`=1 with `full_dup`=0 gives `led_on`=1 and `led_colour_b`=1 (colour B) from the next edge.
- R10: In enhanced mode, `link_ok`=0 gives `led_on`=0 and `led_colour_b`=0, and duplex, error and polarity have no effect.
- R11: The mode is sampled from `enh_strap` only while `rst_n` is low (1 selects enhanced, 0 selects normal), and later changes on the strap are ignored.
- R12: Each port's LED depends only on that port's own status bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock (10 MHz nominal) |
| rst_n | input | 1 | Synchronous active-low reset; also the window in which the mode strap is sampled |
| enh_strap | input | 1 | Mode strap: 1 selects enhanced two-colour mode, 0 selects normal mode |
| link_ok | input | NUM_PORTS | Per-port link good |
| pol_ok | input | NUM_PORTS | Per-port receive polarity correct |
| full_dup | input | NUM_PORTS | Per-port full-duplex indication |
| err_flag | input | NUM_PORTS | Per-port error flag (register bit 7, set by management) |
| led_on | output | NUM_PORTS | Per-port LED lit |
| led_colour_b | output | NUM_PORTS | Per-port colour select in enhanced mode: 0 is colour A, 1 is colour B |

## Verification
A change on the status inputs reaches the LED on the first clock edge after it. That edge moves the state register, and the outputs are decoded from state alone. A blink inverts on the edge of the `FAST_HALF_TICKS`-th or `SLOW_HALF_TICKS`-th prescaler tick after the condition changed. The prescaler is free-running and ticks on every edge whose count since reset release is a multiple of `TICK_DIV`. The bench numbers clock edges from reset release and tags each expected LED vector with the edge it belongs to. Its monitor compares that vector at the falling edge that follows, so each check lands exactly on the cycle when the result is due.

// File: rtl/led_pkg.sv
package led_pkg;

    // Displayed condition of one port LED
    typedef enum logic [2:0] {
        LED_DARK       = 3'd0,
        LED_SOLID      = 3'd1,
        LED_FAST_BLINK = 3'd2,
        LED_SLOW_BLINK = 3'd3,
        LED_COLOUR_A   = 3'd4,
        LED_COLOUR_B   = 3'd5
    } led_state_e;

endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
    parameter int TICK_DIV = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_cnt;

    // Free-running divider, one tick per TICK_DIV clocks
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (div_cnt == LAST) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    assign tick = (div_cnt == LAST);

endmodule

// File: rtl/led_port_fsm.sv
module led_port_fsm
    import led_pkg::*;
#(
    parameter int FAST_HALF_TICKS = 200,
    parameter int SLOW_HALF_TICKS = 800
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enh,
    input  logic tick,
    input  logic link_ok,
    input  logic pol_ok,
    input  logic full_dup,
    input  logic err_flag,
    output logic led_on,
    output logic led_colour_b
);
    localparam int MAXH = (FAST_HALF_TICKS > SLOW_HALF_TICKS) ? FAST_HALF_TICKS : SLOW_HALF_TICKS;
    localparam int HW   = $clog2((MAXH > 1) ? MAXH : 2);
    localparam logic [HW-1:0] FAST_LIM = HW'(FAST_HALF_TICKS - 1);
    localparam logic [HW-1:0] SLOW_LIM = HW'(SLOW_HALF_TICKS - 1);

    led_state_e    state, target;
    logic [HW-1:0] half_cnt;
    logic [HW-1:0] half_lim;
    logic          lit_phase;
    logic          blinking;

    // Target condition: enhanced decodes link/duplex, normal ranks faults
    always_comb begin
        if (enh) begin
            if (!link_ok)      target = LED_DARK;
            else if (full_dup) target = LED_COLOUR_A;
            else               target = LED_COLOUR_B;
        end else begin
            if (err_flag)      target = LED_SOLID;
            else if (!link_ok) target = LED_FAST_BLINK;
            else if (!pol_ok)  target = LED_SLOW_BLINK;
            else               target = LED_DARK;
        end
    end

    assign blinking = (state == LED_FAST_BLINK) || (state == LED_SLOW_BLINK);
    assign half_lim = (state == LED_FAST_BLINK) ? FAST_LIM : SLOW_LIM;

    // State register with blink phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= LED_DARK;
            half_cnt  <= '0;
            lit_phase <= 1'b0;
        end else if (target != state) begin
            state     <= target;
            half_cnt  <= '0;
            lit_phase <= 1'b1;
        end else if (blinking && tick) begin
            if (half_cnt == half_lim) begin
                half_cnt  <= '0;
                lit_phase <= ~lit_phase;
            end else begin
                half_cnt  <= half_cnt + 1'b1;
            end
        end
    end

    // Output decode from state only
    always_comb begin
        led_on       = 1'b0;
        led_colour_b = 1'b0;
        unique case (state)
            LED_DARK:       led_on = 1'b0;
            LED_SOLID:      led_on = 1'b1;
            LED_FAST_BLINK: led_on = lit_phase;
            LED_SLOW_BLINK: led_on = lit_phase;
            LED_COLOUR_A:   led_on = 1'b1;
            LED_COLOUR_B: begin
                led_on       = 1'b1;
                led_colour_b = 1'b1;
            end
            default:        led_on = 1'b0;
        endcase
    end

endmodule

// File: rtl/port_led_ctrl.sv
module port_led_ctrl #(
    parameter int NUM_PORTS       = 4,
    parameter int TICK_DIV        = 10000,
    parameter int FAST_HALF_TICKS = 200,
    parameter int SLOW_HALF_TICKS = 800
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enh_strap,
    input  logic [NUM_PORTS-1:0] link_ok,
    input  logic [NUM_PORTS-1:0] pol_ok,
    input  logic [NUM_PORTS-1:0] full_dup,
    input  logic [NUM_PORTS-1:0] err_flag,
    output logic [NUM_PORTS-1:0] led_on,
    output logic [NUM_PORTS-1:0] led_colour_b
);
    logic enh_mode;
    logic tick;

    // Mode strap captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enh_mode <= enh_strap;
        end
    end

    led_tick_gen #(
        .TICK_DIV(TICK_DIV)
    ) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        led_port_fsm #(
            .FAST_HALF_TICKS(FAST_HALF_TICKS),
            .SLOW_HALF_TICKS(SLOW_HALF_TICKS)
        ) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .enh         (enh_mode),
            .tick        (tick),
            .link_ok     (link_ok[g]),
            .pol_ok      (pol_ok[g]),
            .full_dup    (full_dup[g]),
            .err_flag    (err_flag[g]),
            .led_on      (led_on[g]),
            .led_colour_b(led_colour_b[g])
        );
    end

endmodule

// File: rtl/led_ctrl_chk.sv
module led_ctrl_chk #(
    parameter int NUM_PORTS = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 enh,
    input logic [NUM_PORTS-1:0] link_ok,
    input logic [NUM_PORTS-1:0] pol_ok,
    input logic [NUM_PORTS-1:0] full_dup,
    input logic [NUM_PORTS-1:0] err_flag,
    input logic [NUM_PORTS-1:0] led_on,
    input logic [NUM_PORTS-1:0] led_colour_b
);
    // R11
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(enh));

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_chk
        // R2
        good_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!enh && !err_flag[g] && link_ok[g] && pol_ok[g]) |=> !led_on[g]);

        // R3
        err_solid_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!enh && err_flag[g]) |=> led_on[g]);

        // R8
        colour_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enh && link_ok[g] && full_dup[g]) |=> (led_on[g] && !led_colour_b[g]));

        // R9
        colour_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enh && link_ok[g] && !full_dup[g]) |=> (led_on[g] && led_colour_b[g]));

        // R10
        enh_down_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (enh && !link_ok[g]) |=> (!led_on[g] && !led_colour_b[g]));
    end

endmodule

bind port_led_ctrl led_ctrl_chk #(
    .NUM_PORTS(NUM_PORTS)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .enh         (enh_mode),
    .link_ok     (link_ok),
    .pol_ok      (pol_ok),
    .full_dup    (full_dup),
    .err_flag    (err_flag),
    .led_on      (led_on),
    .led_colour_b(led_colour_b)
);

// File: tb/port_led_ctrl_bench.sv
module port_led_ctrl_bench;
    localparam int NP = 4;
    localparam int TD = 3;
    localparam int FH = 2;
    localparam int SH = 5;

    localparam int C_DARK  = 0;
    localparam int C_SOLID = 1;
    localparam int C_FAST  = 2;
    localparam int C_SLOW  = 3;
    localparam int C_A     = 4;
    localparam int C_B     = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          strap = 1'b0;
    logic [NP-1:0] link = '0;
    logic [NP-1:0] pol = '0;
    logic [NP-1:0] fdx = '0;
    logic [NP-1:0] err = '0;
    logic [NP-1:0] led;
    logic [NP-1:0] colb;

    int n_chk = 0;
    int n_fail = 0;
    int edge_cnt = 0;
    bit done = 0;

    typedef struct {
        int            at;
        logic [NP-1:0] on;
        logic [NP-1:0] cb;
        string         req;
    } exp_t;
    exp_t q[$];

    // Reference model: displayed condition, ticks since it began, latched mode
    int m_st[NP];
    int m_tk[NP];
    bit m_enh;

    always #5 clk = ~clk;

    port_led_ctrl #(
        .NUM_PORTS      (NP),
        .TICK_DIV       (TD),
        .FAST_HALF_TICKS(FH),
        .SLOW_HALF_TICKS(SH)
    ) u_port_led_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .enh_strap   (strap),
        .link_ok     (link),
        .pol_ok      (pol),
        .full_dup    (fdx),
        .err_flag    (err),
        .led_on      (led),
        .led_colour_b(colb)
    );

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    function automatic int want_cond(int p);
        if (m_enh) begin
            if (!link[p]) return C_DARK;
            return fdx[p] ? C_A : C_B;
        end
        if (err[p])   return C_SOLID;
        if (!link[p]) return C_FAST;
        if (!pol[p])  return C_SLOW;
        return C_DARK;
    endfunction

    // Driver: predict the LED vector on each of the next n edges, then hold
    task automatic run_window(input int n, input string req);
        for (int k = 1; k <= n; k++) begin
            exp_t it;
            it.at  = edge_cnt + k;
            it.req = req;
            it.on  = '0;
            it.cb  = '0;
            for (int p = 0; p < NP; p++) begin
                int c;
                c = want_cond(p);
                if (c != m_st[p]) begin
                    m_st[p] = c;
                    m_tk[p] = 0;
                end else if ((it.at % TD) == 0) begin
                    m_tk[p] = m_tk[p] + 1;
                end
                case (m_st[p])
                    C_SOLID: it.on[p] = 1'b1;
                    C_FAST:  it.on[p] = ((m_tk[p] / FH) % 2) == 0;
                    C_SLOW:  it.on[p] = ((m_tk[p] / SH) % 2) == 0;
                    C_A:     it.on[p] = 1'b1;
                    C_B: begin
                        it.on[p] = 1'b1;
                        it.cb[p] = 1'b1;
                    end
                    default: it.on[p] = 1'b0;
                endcase
            end
            q.push_back(it);
        end
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic s);
        wait (q.size() == 0);
        @(negedge clk);
        rst_n = 1'b0;
        strap = s;
        repeat (3) @(negedge clk);
        n_chk++;
        if (led !== '0 || colb !== '0) begin
            n_fail++;
            $display("FAIL R1: led=%b colb=%b expected led=0000 colb=0000", led, colb);
        end
        m_enh = s;
        for (int p = 0; p < NP; p++) begin
            m_st[p] = C_DARK;
            m_tk[p] = 0;
        end
        rst_n = 1'b1;
    endtask

    // Monitor: pop the item due on this edge and compare
    always @(negedge clk) begin
        if (rst_n && q.size() > 0 && q[0].at == edge_cnt) begin
            exp_t it;
            it = q.pop_front();
            n_chk++;
            if (led !== it.on || colb !== it.cb) begin
                n_fail++;
                $display("FAIL %s: edge %0d led=%b colb=%b expected led=%b colb=%b",
                         it.req, it.at, led, colb, it.on, it.cb);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        // Normal mode (strap low)
        do_reset(1'b0);
        link = '1; pol = '1; fdx = 4'b0101; err = '0;
        run_window(6, "R2");
        // port0 error plus lost link, port1 lost link, port2 bad polarity, port3 good
        err  = 4'b0001;
        link = 4'b1100;
        pol  = 4'b1011;
        run_window(40, "R3/R4/R5/R12");
        // port1 gains bad polarity too: lost link still wins
        pol  = 4'b1001;
        run_window(20, "R6");
        // port0 error clears: falls to fast blink, restarting lit
        err  = 4'b0000;
        run_window(20, "R7");
        // port2 polarity restored then broken again mid-blink
        pol[2] = 1'b1;
        run_window(4, "R7");
        pol[2] = 1'b0;
        run_window(30, "R5/R7");
        // port1 link returns with polarity bad: lost link to slow blink
        link[1] = 1'b1;
        run_window(30, "R6/R7");

        // Enhanced mode, strap dropped after reset
        do_reset(1'b1);
        strap = 1'b0;
        link = 4'b0011; fdx = 4'b0101; err = 4'b1000; pol = 4'b0111;
        run_window(10, "R8/R9/R10/R11");
        link = 4'b0110; fdx = 4'b0011; err = 4'b1111; pol = 4'b0000;
        run_window(10, "R8/R9/R10/R11");

        // Back to normal mode
        do_reset(1'b0);
        link = 4'b0111; pol = 4'b1101; err = 4'b0010; fdx = '0;
        run_window(30, "R11/R3/R5/R4");

        wait (q.size() == 0);
        @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule